// File: doc/BRIEF.md
# I/O Window Decoder with Counter Clock and Interrupt Steering

This block is the glue logic of an 8-bit I/O module that sits on a legacy expansion bus. It watches the 10-bit I/O address. When the upper six bits equal the board's base setting, it claims a window of 16 bytes. Within that window it produces active-low chip selects for two parallel port controllers and a triple counter/timer, and passes the two low address bits on to them. It also holds two small local registers: a counter input-select register and an interrupt configuration register.

The counter input-select register steers the clock input of each counter. The source can be an external pin, a 4 MHz oscillator tick, or the output of the counter before it. Chaining counters in this way builds 32- or 48-bit cascades. The interrupt register chooses, for each of three interrupt lines, between a port-pin source and a counter output. It also enables the line's output driver. An enabled line with a pending source is driven high. In every other case it is left floating. The block brings this out as a per-line output-enable for a pad that drives a constant high. The port controllers and counters are outside the block. They appear only as chip selects, read-data inputs, port C bit 0 inputs and counter outputs.

Top module: `io_window_glue`

## Requirements
- R1: The window is hit when addr[9:4] equals base_cfg. On a hit, offsets 0–3 drive ppi0_cs_n low, offsets 4–7 drive ppi1_cs_n low, and offsets 8–11 drive ctc_cs_n low. Offsets 12–15 and any miss leave all three selects high. At most one select is ever low.
- R2: sub_addr always equals addr[1:0].
- R3: A local register is written only at the clock edge that first sees iow_n high after it was low. The address and data are the values present while iow_n was low. A write outside the window, or to offsets 0–11, changes neither local register. Nothing changes while the strobe is still held low.
- R4: Offset 13 reaches the same register as offset 12, and offset 15 reaches the same register as offset 14, for both reads and writes.
- R5: The counter select register reads back as {000, sel2[1:0], sel1[1:0], sel0}. The interrupt register reads back as {0, en[2:0], 0, src[2:0]}. Unused bits read as 0.
- R6: Synchronous active-low reset clears both local registers to 0. This selects the external clock inputs and disables every interrupt line.
- R7: data_oe is 1 exactly when ior_n is low and the window is hit. During such a read, offsets 0–3 return ppi0_rdata, 4–7 return ppi1_rdata, 8–11 return ctc_rdata, and 12–15 return the local registers.
- R8: ctr_clk[0] is osc_tick when sel0 is 1 and ext_clk[0] when sel0 is 0.
- R9: For counters n = 1 and 2, the 2-bit select picks ctr_clk[n] as ext_clk[n] for 00, osc_tick for 01, and ctr_out[n-1] for 1X.
- R10: Interrupt source 0 is ppi0_pc0 when src[0]=0 and ctr_out[0] when src[0]=1. Source 1 is ppi1_pc0 or ctr_out[1]. Source 2 is ext_irq or ctr_out[2].
- R11: irq_oe[n] is 1 only when en[n] is 1 and source n is high. Otherwise it is 0, which leaves the line high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_cfg | input | 6 | Board base setting compared with addr[9:4] |
| addr | input | 10 | I/O address |
| ior_n | input | 1 | Read strobe, active low |
| iow_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Write data from the bus |
| data_out | output | 8 | Read data toward the bus |
| data_oe | output | 1 | Bus data driver enable |
| sub_addr | output | 2 | Register select passed to the child devices |
| ppi0_cs_n | output | 1 | First port controller select, active low |
| ppi1_cs_n | output | 1 | Second port controller select, active low |
| ctc_cs_n | output | 1 | Counter/timer select, active low |
| ppi0_rdata | input | 8 | Read data from the first port controller |
| ppi1_rdata | input | 8 | Read data from the second port controller |
| ctc_rdata | input | 8 | Read data from the counter/timer |
| ext_clk | input | 3 | External counter clock pins |
| osc_tick | input | 1 | 4 MHz oscillator tick |
| ctr_out | input | 3 | Counter outputs |
| ctr_clk | output | 3 | Steered counter clock inputs |
| ppi0_pc0 | input | 1 | Port C bit 0 of the first port controller |
| ppi1_pc0 | input | 1 | Port C bit 0 of the second port controller |
| ext_irq | input | 1 | External interrupt pin |
| irq_oe | output | 3 | Interrupt line drive enables (pad drives high) |

## Verification
The decoder is swept over all 1024 addresses with one base setting, and over all 64 base settings with one fixed address. This separates hits from misses and tells each device range apart from the local-register range. The counter steering is tried with every one of the 32 select codes against all 128 combinations of external pins, oscillator tick and counter outputs. Each mux leg is therefore seen to be chosen and the other legs seen to be ignored. The interrupt path is tried with all 64 source/enable codes against all 64 combinations of port pins, external pin and counter outputs. Directed writes cover the aliased offsets, misses, writes to child offsets, and a strobe held low.

// File: rtl/io_glue_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and the offset-range type for the I/O window glue.
// Assumes a 16-byte window split into four 4-byte ranges.
package io_glue_pkg;
    localparam int OFF_W  = 4;   // byte offsets inside the window
    localparam int EN_LSB = 4;   // first enable bit in the interrupt register

    typedef enum logic [1:0] {
        TGT_PORT0 = 2'd0,
        TGT_PORT1 = 2'd1,
        TGT_TIMER = 2'd2,
        TGT_LOCAL = 2'd3
    } tgt_e;

    // Map the upper two offset bits to the range they address.
    function automatic tgt_e target_of(input logic [1:0] quad);
        return tgt_e'(quad);
    endfunction
endpackage

// File: rtl/window_decode.sv
`timescale 1ns/1ps
// Module: window_decode
// Compares the upper address bits with the base setting and splits off the
// byte offset. Assumes the address is exactly BASE_W + OFF_W bits wide.
module window_decode #(
    parameter int BASE_W = 6,
    parameter int OFF_W  = 4,
    parameter int ADDR_W = BASE_W + OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BASE_W-1:0] base_cfg,
    output logic              hit,
    output logic [OFF_W-1:0]  offset
);
    // Window match and offset extraction.
    always_comb begin
        hit    = (addr[ADDR_W-1 -: BASE_W] == base_cfg);
        offset = addr[OFF_W-1:0];
    end
endmodule

// File: rtl/cfg_regs.sv
`timescale 1ns/1ps
// Module: cfg_regs
// Holds the counter select and interrupt configuration registers. The address
// decision and data are latched while the write strobe is low. They are
// committed on the first clock that sees the strobe high again. Assumes the
// strobes are already synchronous to clk.
module cfg_regs #(
    parameter int N_CTR  = 3,
    parameter int CSEL_W = 2 * N_CTR - 1,
    parameter int EN_LSB = 4,
    parameter int LAT_W  = EN_LSB + N_CTR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iow_n,
    input  logic              sel_local,
    input  logic              sel_irq,
    input  logic [LAT_W-1:0]  wdata,
    output logic [CSEL_W-1:0] cnt_sel,
    output logic [N_CTR-1:0]  irq_src,
    output logic [N_CTR-1:0]  irq_en
);
    logic             wr_q;
    logic             lat_local;
    logic             lat_irq;
    logic [LAT_W-1:0] lat_data;
    logic             commit;

    // Capture the strobe history and the write target while the strobe is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q      <= 1'b1;
            lat_local <= 1'b0;
            lat_irq   <= 1'b0;
            lat_data  <= '0;
        end else begin
            wr_q <= iow_n;
            if (!iow_n) begin
                lat_local <= sel_local;
                lat_irq   <= sel_irq;
                lat_data  <= wdata;
            end
        end
    end

    // A write completes on the strobe's rising edge.
    always_comb commit = iow_n && !wr_q && lat_local;

    // Update whichever register the latched offset selected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_sel <= '0;
            irq_src <= '0;
            irq_en  <= '0;
        end else if (commit) begin
            if (lat_irq) begin
                irq_src <= lat_data[N_CTR-1:0];
                irq_en  <= lat_data[EN_LSB +: N_CTR];
            end else begin
                cnt_sel <= lat_data[CSEL_W-1:0];
            end
        end
    end

    // R3
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(iow_n) |=> $stable({cnt_sel, irq_src, irq_en}));
endmodule

// File: rtl/clk_steer.sv
`timescale 1ns/1ps
// Module: clk_steer
// Picks each counter's clock input. Counter 0 uses a 1-bit select; later
// counters use 2 bits and may take the previous counter's output.
// Assumes the select register layout {.., sel2, sel1, sel0}.
module clk_steer #(
    parameter int N_CTR  = 3,
    parameter int CSEL_W = 2 * N_CTR - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSEL_W-1:0] cnt_sel,
    input  logic [N_CTR-1:0]  ext_clk,
    input  logic              osc_tick,
    input  logic [N_CTR-1:0]  ctr_out,
    output logic [N_CTR-1:0]  ctr_clk
);
    // First counter: external pin or oscillator.
    always_comb ctr_clk[0] = cnt_sel[0] ? osc_tick : ext_clk[0];

    genvar gi;
    generate
        for (gi = 1; gi < N_CTR; gi++) begin : g_chain
            logic [1:0] sel;
            // Later counters: external pin, oscillator, or previous counter.
            always_comb begin
                sel = cnt_sel[2*gi -: 2];
                if (sel[1])      ctr_clk[gi] = ctr_out[gi-1];
                else if (sel[0]) ctr_clk[gi] = osc_tick;
                else             ctr_clk[gi] = ext_clk[gi];
            end
        end
    endgenerate

    // R8
    first_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctr_clk[0] == ext_clk[0]) || (ctr_clk[0] == osc_tick));
endmodule

// File: rtl/irq_route.sv
`timescale 1ns/1ps
// Module: irq_route
// For each interrupt line, selects a pin source or a counter output and
// enables the pad driver only when the line is enabled and the source is high.
module irq_route #(
    parameter int N_CTR = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CTR-1:0] irq_src,
    input  logic [N_CTR-1:0] irq_en,
    input  logic [N_CTR-1:0] pin_src,
    input  logic [N_CTR-1:0] ctr_out,
    output logic [N_CTR-1:0] irq_oe
);
    genvar gi;
    generate
        for (gi = 0; gi < N_CTR; gi++) begin : g_line
            logic pend;
            // Source choice and gated drive for one line.
            always_comb begin
                pend       = irq_src[gi] ? ctr_out[gi] : pin_src[gi];
                irq_oe[gi] = irq_en[gi] && pend;
            end

            // R11
            drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_oe[gi] |-> irq_en[gi]);
        end
    endgenerate
endmodule

// File: rtl/io_window_glue.sv
`timescale 1ns/1ps
// Module: io_window_glue (top)
// Decodes the 16-byte I/O window, selects the child devices, serves the two
// local registers and steers counter clocks and interrupt lines.
// Assumes synchronous strobes and a pad that drives high when irq_oe is set.
module io_window_glue
    import io_glue_pkg::*;
#(
    parameter int BASE_W = 6,
    parameter int DATA_W = 8,
    parameter int N_CTR  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [5:0]        base_cfg,
    input  logic [9:0]        addr,
    input  logic              ior_n,
    input  logic              iow_n,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe,
    output logic [1:0]        sub_addr,
    output logic              ppi0_cs_n,
    output logic              ppi1_cs_n,
    output logic              ctc_cs_n,
    input  logic [7:0]        ppi0_rdata,
    input  logic [7:0]        ppi1_rdata,
    input  logic [7:0]        ctc_rdata,
    input  logic [2:0]        ext_clk,
    input  logic              osc_tick,
    input  logic [2:0]        ctr_out,
    output logic [2:0]        ctr_clk,
    input  logic              ppi0_pc0,
    input  logic              ppi1_pc0,
    input  logic              ext_irq,
    output logic [2:0]        irq_oe
);
    localparam int ADDR_W = BASE_W + OFF_W;
    localparam int CSEL_W = 2 * N_CTR - 1;
    localparam int LAT_W  = EN_LSB + N_CTR;
    localparam int PAD_W  = EN_LSB - N_CTR;

    logic              hit;
    logic [OFF_W-1:0]  offset;
    tgt_e              tgt;
    logic [CSEL_W-1:0] cnt_sel;
    logic [N_CTR-1:0]  irq_src;
    logic [N_CTR-1:0]  irq_en;
    logic [DATA_W-1:0] csel_byte;
    logic [DATA_W-1:0] irq_byte;
    logic              din_unused;
    logic              off_unused;

    window_decode #(.BASE_W(BASE_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)) u_dec (
        .addr     (addr),
        .base_cfg (base_cfg),
        .hit      (hit),
        .offset   (offset)
    );

    // Range decode and child selects.
    always_comb begin
        tgt        = target_of(offset[OFF_W-1 -: 2]);
        ppi0_cs_n  = !(hit && tgt == TGT_PORT0);
        ppi1_cs_n  = !(hit && tgt == TGT_PORT1);
        ctc_cs_n   = !(hit && tgt == TGT_TIMER);
        sub_addr   = addr[1:0];
        din_unused = data_in[DATA_W-1];
        off_unused = offset[0];
    end

    cfg_regs #(.N_CTR(N_CTR), .CSEL_W(CSEL_W), .EN_LSB(EN_LSB), .LAT_W(LAT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .iow_n     (iow_n),
        .sel_local (hit && tgt == TGT_LOCAL),
        .sel_irq   (offset[1]),
        .wdata     (data_in[LAT_W-1:0]),
        .cnt_sel   (cnt_sel),
        .irq_src   (irq_src),
        .irq_en    (irq_en)
    );

    // Read-back formatting and read data mux.
    always_comb begin
        csel_byte = DATA_W'(cnt_sel);
        irq_byte  = DATA_W'({irq_en, {PAD_W{1'b0}}, irq_src});
        unique case (tgt)
            TGT_PORT0: data_out = ppi0_rdata;
            TGT_PORT1: data_out = ppi1_rdata;
            TGT_TIMER: data_out = ctc_rdata;
            TGT_LOCAL: data_out = offset[1] ? irq_byte : csel_byte;
        endcase
        data_oe = hit && !ior_n;
    end

    clk_steer #(.N_CTR(N_CTR), .CSEL_W(CSEL_W)) u_clk (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_sel  (cnt_sel),
        .ext_clk  (ext_clk),
        .osc_tick (osc_tick),
        .ctr_out  (ctr_out),
        .ctr_clk  (ctr_clk)
    );

    irq_route #(.N_CTR(N_CTR)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_src (irq_src),
        .irq_en  (irq_en),
        .pin_src ({ext_irq, ppi1_pc0, ppi0_pc0}),
        .ctr_out (ctr_out),
        .irq_oe  (irq_oe)
    );

    // R1
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!ppi0_cs_n, !ppi1_cs_n, !ctc_cs_n}));

    // R7
    bus_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> !ior_n);
endmodule

// File: tb/io_window_glue_tb.sv
`timescale 1ns/1ps
module io_window_glue_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] base_cfg = 6'h30;
    logic [9:0] addr = '0;
    logic       ior_n = 1'b1, iow_n = 1'b1;
    logic [7:0] data_in = '0, data_out;
    logic       data_oe;
    logic [1:0] sub_addr;
    logic       ppi0_cs_n, ppi1_cs_n, ctc_cs_n;
    logic [7:0] ppi0_rdata = 8'h11, ppi1_rdata = 8'h22, ctc_rdata = 8'h33;
    logic [2:0] ext_clk = '0, ctr_out = '0, ctr_clk, irq_oe;
    logic       osc_tick = 1'b0, ppi0_pc0 = 1'b0, ppi1_pc0 = 1'b0, ext_irq = 1'b0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    io_window_glue u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; data_in = d; iow_n = 1'b0;
        @(negedge clk); iow_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [9:0] a, input logic [7:0] exp, input string req);
        @(negedge clk); addr = a; ior_n = 1'b0;
        #1;
        check(req, {data_oe, data_out}, {1'b1, exp});
        ior_n = 1'b1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic [2:0] exp_clk(logic [4:0] s, logic [2:0] e, logic o, logic [2:0] c);
        logic [2:0] r;
        r[0] = s[0] ? o : e[0];
        r[1] = s[2] ? c[0] : (s[1] ? o : e[1]);
        r[2] = s[4] ? c[1] : (s[3] ? o : e[2]);
        return r;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        do_reset();
        // R6: reset state
        bus_read(10'h30C, 8'h00, "R6 csel reset");
        bus_read(10'h30E, 8'h00, "R6 irq reset");
        ctr_out = 3'b111; ext_irq = 1'b1; ppi0_pc0 = 1'b1; ppi1_pc0 = 1'b1; #1;
        check("R6 irq disabled", irq_oe, 3'b000);
        ctr_out = '0; ext_irq = 0; ppi0_pc0 = 0; ppi1_pc0 = 0;

        // R1 R2 R7: full address sweep, no read strobe
        @(negedge clk);
        for (int a = 0; a < 1024; a++) begin
            logic h;
            logic [2:0] cs;
            addr = a[9:0]; #1;
            h  = (a[9:4] == 6'h30);
            cs = 3'b111;
            if (h && a[3:2] == 2'd0) cs = 3'b011;
            if (h && a[3:2] == 2'd1) cs = 3'b101;
            if (h && a[3:2] == 2'd2) cs = 3'b110;
            check("R1 selects", {ppi0_cs_n, ppi1_cs_n, ctc_cs_n}, cs);
            check("R2 sub_addr", sub_addr, a[1:0]);
            check("R7 idle no drive", data_oe, 1'b0);
        end
        // R1: base setting sweep at fixed address 0x2A5
        for (int b = 0; b < 64; b++) begin
            base_cfg = b[5:0]; addr = 10'h2A5; #1;
            check("R1 base match", ppi1_cs_n, (b == 6'h2A) ? 1'b0 : 1'b1);
        end
        base_cfg = 6'h30;

        // R7: child read data and miss
        for (int o = 0; o < 12; o++)
            bus_read(10'h300 + 10'(o), (o < 4) ? 8'h11 : (o < 8) ? 8'h22 : 8'h33, "R7 child data");
        @(negedge clk); addr = 10'h10C; ior_n = 1'b0; #1;
        check("R7 miss read", data_oe, 1'b0);
        ior_n = 1'b1;

        // R4 R5: aliasing and read-back format
        bus_write(10'h30C, 8'hFF);
        bus_read(10'h30C, 8'h1F, "R5 csel format");
        bus_read(10'h30D, 8'h1F, "R4 alias 13 read");
        bus_write(10'h30D, 8'h0A);
        bus_read(10'h30C, 8'h0A, "R4 alias 13 write");
        bus_write(10'h30F, 8'hFF);
        bus_read(10'h30E, 8'h77, "R5 irq format");
        bus_read(10'h30F, 8'h77, "R4 alias 15 read");

        // R3: misses and child offsets leave local registers alone
        bus_write(10'h20C, 8'h00);
        bus_write(10'h20E, 8'h00);
        bus_write(10'h305, 8'h00);
        bus_write(10'h30A, 8'h00);
        bus_read(10'h30C, 8'h0A, "R3 csel untouched");
        bus_read(10'h30E, 8'h77, "R3 irq untouched");

        // R3: no change while strobe held low, change after release
        ctr_out = 3'b111; #1;
        check("R3 before write", irq_oe, 3'b111);
        @(negedge clk); addr = 10'h30E; data_in = 8'h00; iow_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 strobe held", irq_oe, 3'b111);
        iow_n = 1'b1;
        @(negedge clk);
        check("R3 after release", irq_oe, 3'b000);
        ctr_out = '0;

        // R8 R9: every select code against every input pattern
        for (int s = 0; s < 32; s++) begin
            bus_write(10'h30C, s[7:0]);
            for (int v = 0; v < 128; v++) begin
                logic [2:0] e;
                {ext_clk, osc_tick, ctr_out} = v[6:0]; #1;
                e = exp_clk(s[4:0], ext_clk, osc_tick, ctr_out);
                check("R8 counter0 clock", ctr_clk[0], e[0]);
                check("R9 chained clocks", ctr_clk[2:1], e[2:1]);
            end
        end

        // R10 R11: every source/enable code against every input pattern
        for (int c = 0; c < 64; c++) begin
            bus_write(10'h30E, {1'b0, c[5:3], 1'b0, c[2:0]});
            for (int v = 0; v < 64; v++) begin
                logic [2:0] pins, srcv;
                {ext_irq, ppi1_pc0, ppi0_pc0, ctr_out} = v[5:0]; #1;
                pins = {ext_irq, ppi1_pc0, ppi0_pc0};
                srcv = (c[2:0] & ctr_out) | (~c[2:0] & pins);
                check("R10 R11 irq drive", irq_oe, c[5:3] & srcv);
                if (c[5:3] == 3'b000) check("R11 disabled floats", irq_oe, 3'b000);
            end
        end

        // R6: reset clears after use
        do_reset();
        bus_read(10'h30C, 8'h00, "R6 csel cleared");
        bus_read(10'h30E, 8'h00, "R6 irq cleared");

        finish_run();
    end
endmodule